// File: doc/BRIEF.md
# Mutable-Unit Dispatch Steering and In-Order Station

This block sits at the dispatch stage of an out-of-order superscalar core, beside register rename. It looks at each decoded instruction in the incoming bundle and picks the reservation station that receives it. One of those stations belongs to this block. It feeds a functional unit that works either as a floating-point adder or as an integer ALU and address generator. Floating-point additions always go to that station. Integer and memory work is sent there only while a credit counter can pay for it. Multiply, divide and square-root stay on the ordinary floating-point station. The steering decision is combinational from the bundle and the current state, so it adds no pipeline stage.

The block's own station is a small circular queue that issues strictly from its head. The head issues once both of its source operands are ready. Ready bits are set by result tags broadcast from the rest of the core. If the head needs the other unit mode, the unit changes mode first, and nothing issues during that change. A memory instruction placed in the station is also copied into the address station. The mutable unit only computes its address, and the copy stays there until the access finishes. A flush clears the station and puts the unit back in floating-point mode.

Top module: `mfu_dispatch_top`

## Requirements
- R1: A valid floating-point add (class code 2) that is accepted is routed to the mutable station (route code 3). A multiply/divide/square-root (class code 3) is always routed to the ordinary floating-point station (route code 2), even when the mutable station is full.
- R2: Let n be the number of valid integer (class 0) and memory (class 1) slots in a bundle. When the credit is at least 4*n, those slots are eligible for the mutable station and the credit is reduced by 4*n. Otherwise integer slots go to the integer station (route 0) and memory slots to the address station (route 1), and the credit is not reduced. Credit exactly equal to 4*n counts as sufficient.
- R3: An eligible integer or memory slot that would not fit is sent to its ordinary station. It does not fit when the slots ahead of it plus the floating-point adds still to come would already fill the free entries.
- R4: A memory slot placed in the mutable station also raises its address-copy bit. No other slot raises it.
- R5: When the floating-point adds in a bundle outnumber the free entries, the stall output is high and no slot of that bundle is routed (all route-valid bits low). The station never holds more than its depth of 8 entries.
- R6: The station issues only its oldest entry. A younger ready entry waits behind a head whose operands are not ready.
- R7: The head issues only when both of its source-ready bits are set. Bit 0 of each slot's ready pair belongs to source 0, bit 1 to source 1.
- R8: If the head needs a mode other than the unit's current one (add = mode 0, integer or memory = mode 1), the unit switches. No issue happens in the detection cycle or in the PENALTY (default 2) cycles after it, so the head issues PENALTY+1 cycles after the mismatch first appears. Every issue carries the unit's current mode.
- R9: A broadcast tag that matches a stored source tag sets that source's ready bit. The entry can issue in the next cycle.
- R10: In a flush cycle nothing is routed. After the flush the station is empty and the unit is in floating-point mode.
- R11: The credit starts at its maximum of 16. It gains 3 every cycle after any deduction and saturates at 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Mispredict flush: empties the station, resets the mode |
| disp_valid | input | W | Per-slot valid of the dispatch bundle |
| disp_cls | input | 2*W | Per-slot op class: 0 integer, 1 memory, 2 fp add, 3 fp mul/div/sqrt |
| disp_src0 | input | W*TAGW | Per-slot source 0 tag |
| disp_src1 | input | W*TAGW | Per-slot source 1 tag |
| disp_rdy | input | 2*W | Per-slot source ready bits from rename |
| disp_dst | input | W*TAGW | Per-slot destination tag |
| bc_valid | input | NB | Result broadcast valid per port |
| bc_tag | input | NB*TAGW | Result broadcast tags |
| route_valid | output | W | Slot accepted and routed this cycle |
| route_dest | output | 2*W | Per-slot route: 0 integer, 1 address, 2 fp, 3 mutable |
| addr_copy | output | W | Memory slot also written into the address station |
| disp_stall | output | 1 | Bundle not accepted, mutable station lacks room for its adds |
| iss_valid | output | 1 | Head entry issues to the mutable unit |
| iss_mode | output | 1 | Unit mode for the issue: 0 fp add, 1 integer/address |
| iss_cls | output | 2 | Op class of the issuing entry |
| iss_dst | output | TAGW | Destination tag of the issuing entry |

## Verification
Steering is driven with bundle mixes that walk the credit down through sufficient, exactly sufficient and insufficient values, so the 4*n threshold and the saturation at the top are pinned separately. Mixed integer, memory and add bundles are offered while the station fills. This separates a credit refusal from a capacity refusal and shows that adds claim the last entries ahead of integer work. Issue patterns set a not-ready head in front of a ready younger entry, release operands through each broadcast port, and alternate integer and add entries. The last pattern measures the exact mutation gap and checks the mode carried by each issue.

// File: rtl/mfu_pkg.sv
package mfu_pkg;

  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_MEM  = 2'd1,
    CLS_FADD = 2'd2,
    CLS_FMDS = 2'd3
  } op_cls_e;

  typedef enum logic [1:0] {
    DST_INT  = 2'd0,
    DST_ADDR = 2'd1,
    DST_FP   = 2'd2,
    DST_MFU  = 2'd3
  } route_e;

  localparam logic MODE_FP  = 1'b0;
  localparam logic MODE_INT = 1'b1;

  // unit mode an entry of a given class needs
  function automatic logic mode_of(op_cls_e c);
    return (c == CLS_FADD) ? MODE_FP : MODE_INT;
  endfunction

  function automatic logic int_side(op_cls_e c);
    return (c == CLS_INT) || (c == CLS_MEM);
  endfunction

  // credit after one cycle: optional deduction, refill, saturation
  function automatic int credit_step(int cur, int cost, logic take, int refill, int cap);
    int v;
    v = take ? cur - cost : cur;
    v = v + refill;
    if (v > cap) v = cap;
    return v;
  endfunction

endpackage

// File: rtl/mfu_steer.sv
module mfu_steer
  import mfu_pkg::*;
#(
  parameter int W      = 2,
  parameter int DEPTH  = 8,
  parameter int CMAX   = 16,
  parameter int REFILL = 3,
  parameter int FW     = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [W-1:0]    slot_valid,
  input  logic [2*W-1:0]  slot_cls,
  input  logic [FW-1:0]   free_slots,
  output logic [W-1:0]    route_valid,
  output logic [2*W-1:0]  route_dest,
  output logic [W-1:0]    addr_copy,
  output logic [W-1:0]    alloc,
  output logic            stall
);

  localparam int CW = $clog2(CMAX + 1);

  logic [CW-1:0] credit;
  int   n_side, n_fadd, cost, used, left, free_i;
  logic take, over, accept;

  always_comb begin
    n_side = 0;
    n_fadd = 0;
    for (int i = 0; i < W; i++) begin
      if (slot_valid[i]) begin
        if (int_side(op_cls_e'(slot_cls[2*i +: 2]))) n_side++;
        else if (op_cls_e'(slot_cls[2*i +: 2]) == CLS_FADD) n_fadd++;
      end
    end
    cost   = 4 * n_side;
    take   = int'(credit) >= cost;
    free_i = int'(free_slots);
    over   = n_fadd > free_i;
    stall  = over && !flush;
    accept = !over && !flush;

    route_valid = slot_valid & {W{accept}};
    route_dest  = '0;
    addr_copy   = '0;
    alloc       = '0;
    used = 0;
    left = n_fadd;
    for (int i = 0; i < W; i++) begin
      op_cls_e c;
      c = op_cls_e'(slot_cls[2*i +: 2]);
      if (slot_valid[i]) begin
        case (c)
          CLS_FADD: begin
            route_dest[2*i +: 2] = DST_MFU;
            alloc[i] = accept;
            used++;
            left--;
          end
          CLS_FMDS: route_dest[2*i +: 2] = DST_FP;
          default: begin
            // adds still to come keep their entries reserved
            if (take && (used + 1 + left <= free_i)) begin
              route_dest[2*i +: 2] = DST_MFU;
              alloc[i]     = accept;
              addr_copy[i] = accept && (c == CLS_MEM);
              used++;
            end else begin
              route_dest[2*i +: 2] = (c == CLS_MEM) ? DST_ADDR : DST_INT;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) credit <= CW'(CMAX);
    else        credit <= CW'(credit_step(int'(credit), cost, accept && take, REFILL, CMAX));
  end

  p_credit_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(credit) <= CMAX);

endmodule

// File: rtl/mfu_station.sv
module mfu_station
  import mfu_pkg::*;
#(
  parameter int W     = 2,
  parameter int DEPTH = 8,
  parameter int NB    = 2,
  parameter int TAGW  = 6,
  parameter int FW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [W-1:0]      wr_en,
  input  logic [2*W-1:0]    slot_cls,
  input  logic [W*TAGW-1:0] slot_src0,
  input  logic [W*TAGW-1:0] slot_src1,
  input  logic [2*W-1:0]    slot_rdy,
  input  logic [W*TAGW-1:0] slot_dst,
  input  logic [NB-1:0]     bc_valid,
  input  logic [NB*TAGW-1:0] bc_tag,
  input  logic              pop,
  output logic [FW-1:0]     free_slots,
  output logic              head_valid,
  output logic              head_ready,
  output logic              head_mode,
  output logic [1:0]        head_cls,
  output logic [TAGW-1:0]   head_dst
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0]      e_cls [DEPTH];
  logic [TAGW-1:0] e_s0  [DEPTH];
  logic [TAGW-1:0] e_s1  [DEPTH];
  logic [TAGW-1:0] e_dst [DEPTH];
  logic [1:0]      e_rdy [DEPTH];

  logic [PW-1:0] head, tail;
  logic [FW-1:0] count;
  logic [PW-1:0] wr_idx [W];
  int            n_wr;

  function automatic logic seen(logic [TAGW-1:0] t, logic [NB-1:0] v, logic [NB*TAGW-1:0] tags);
    logic r;
    r = 1'b0;
    for (int b = 0; b < NB; b++)
      if (v[b] && tags[b*TAGW +: TAGW] == t) r = 1'b1;
    return r;
  endfunction

  // consecutive write positions for the accepted slots, in slot order
  always_comb begin
    n_wr = 0;
    for (int i = 0; i < W; i++) begin
      wr_idx[i] = PW'((int'(tail) + n_wr) % DEPTH);
      if (wr_en[i]) n_wr++;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      for (int e = 0; e < DEPTH; e++) e_rdy[e] <= '0;
    end else if (flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++)
        e_rdy[e] <= e_rdy[e] | {seen(e_s1[e], bc_valid, bc_tag), seen(e_s0[e], bc_valid, bc_tag)};
      for (int i = 0; i < W; i++)
        if (wr_en[i])
          e_rdy[wr_idx[i]] <= slot_rdy[2*i +: 2] |
            {seen(slot_src1[i*TAGW +: TAGW], bc_valid, bc_tag),
             seen(slot_src0[i*TAGW +: TAGW], bc_valid, bc_tag)};
      head  <= PW'((int'(head) + (pop ? 1 : 0)) % DEPTH);
      tail  <= PW'((int'(tail) + n_wr) % DEPTH);
      count <= FW'(int'(count) + n_wr - (pop ? 1 : 0));
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < W; i++) begin
      if (wr_en[i]) begin
        e_cls[wr_idx[i]] <= slot_cls[2*i +: 2];
        e_s0[wr_idx[i]]  <= slot_src0[i*TAGW +: TAGW];
        e_s1[wr_idx[i]]  <= slot_src1[i*TAGW +: TAGW];
        e_dst[wr_idx[i]] <= slot_dst[i*TAGW +: TAGW];
      end
    end
  end

  assign head_valid = (count != '0);
  assign head_ready = &e_rdy[head];
  assign head_cls   = e_cls[head];
  assign head_mode  = mode_of(op_cls_e'(e_cls[head]));
  assign head_dst   = e_dst[head];
  assign free_slots = FW'(DEPTH) - count;

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
  p_pop_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid);

endmodule

// File: rtl/mfu_mode_ctl.sv
module mfu_mode_ctl
  import mfu_pkg::*;
#(
  parameter int PENALTY = 2,
  parameter int MW      = $clog2(PENALTY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic head_valid,
  input  logic head_ready,
  input  logic head_mode,
  output logic fire,
  output logic unit_mode
);

  logic [MW-1:0] wait_cnt;
  logic          mismatch, mutating, start;

  assign mismatch = head_valid && (head_mode != unit_mode);
  assign mutating = (wait_cnt != '0);
  assign start    = mismatch && !mutating && !flush;
  assign fire     = head_valid && head_ready && !mismatch && !mutating && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_mode <= MODE_FP;
      wait_cnt  <= '0;
    end else if (flush) begin
      unit_mode <= MODE_FP;
      wait_cnt  <= '0;
    end else if (start) begin
      unit_mode <= head_mode;
      wait_cnt  <= MW'(PENALTY);
    end else if (mutating) begin
      wait_cnt  <= wait_cnt - 1'b1;
    end
  end

  p_hold_after_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_mode != $past(unit_mode)) |-> !fire);

endmodule

// File: rtl/mfu_dispatch_top.sv
module mfu_dispatch_top
  import mfu_pkg::*;
#(
  parameter int W       = 2,
  parameter int DEPTH   = 8,
  parameter int NB      = 2,
  parameter int TAGW    = 6,
  parameter int PENALTY = 2,
  parameter int REFILL  = 3,
  parameter int CMAX    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [W-1:0]       disp_valid,
  input  logic [2*W-1:0]     disp_cls,
  input  logic [W*TAGW-1:0]  disp_src0,
  input  logic [W*TAGW-1:0]  disp_src1,
  input  logic [2*W-1:0]     disp_rdy,
  input  logic [W*TAGW-1:0]  disp_dst,
  input  logic [NB-1:0]      bc_valid,
  input  logic [NB*TAGW-1:0] bc_tag,
  output logic [W-1:0]       route_valid,
  output logic [2*W-1:0]     route_dest,
  output logic [W-1:0]       addr_copy,
  output logic               disp_stall,
  output logic               iss_valid,
  output logic               iss_mode,
  output logic [1:0]         iss_cls,
  output logic [TAGW-1:0]    iss_dst
);

  localparam int FW = $clog2(DEPTH + 1);

  logic [FW-1:0]   free_slots;
  logic [W-1:0]    alloc;
  logic            head_valid, head_ready, head_mode, fire, unit_mode;
  logic [1:0]      head_cls;
  logic [TAGW-1:0] head_dst;

  mfu_steer #(.W(W), .DEPTH(DEPTH), .CMAX(CMAX), .REFILL(REFILL), .FW(FW)) u_steer (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .slot_valid(disp_valid), .slot_cls(disp_cls), .free_slots(free_slots),
    .route_valid(route_valid), .route_dest(route_dest), .addr_copy(addr_copy),
    .alloc(alloc), .stall(disp_stall)
  );

  mfu_station #(.W(W), .DEPTH(DEPTH), .NB(NB), .TAGW(TAGW), .FW(FW)) u_station (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(alloc), .slot_cls(disp_cls), .slot_src0(disp_src0), .slot_src1(disp_src1),
    .slot_rdy(disp_rdy), .slot_dst(disp_dst),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .pop(fire),
    .free_slots(free_slots), .head_valid(head_valid), .head_ready(head_ready),
    .head_mode(head_mode), .head_cls(head_cls), .head_dst(head_dst)
  );

  mfu_mode_ctl #(.PENALTY(PENALTY)) u_mode (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .head_valid(head_valid), .head_ready(head_ready), .head_mode(head_mode),
    .fire(fire), .unit_mode(unit_mode)
  );

  assign iss_valid = fire;
  assign iss_mode  = head_mode;
  assign iss_cls   = head_cls;
  assign iss_dst   = head_dst;

  p_issue_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (iss_mode == unit_mode));

  for (genvar g = 0; g < W; g++) begin : g_slot_chk
    p_addr_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      addr_copy[g] |-> (route_dest[2*g +: 2] == DST_MFU && disp_cls[2*g +: 2] == CLS_MEM));
    p_fmds_fp_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (route_valid[g] && disp_cls[2*g +: 2] == CLS_FMDS) |-> (route_dest[2*g +: 2] == DST_FP));
  end

endmodule

// File: tb/mfu_dispatch_top_test.sv
`timescale 1ns/1ps
module mfu_dispatch_top_test;

  localparam int W = 2, NB = 2, TAGW = 6;

  logic clk = 1'b0;
  logic rst_n, flush;
  logic [W-1:0]       disp_valid;
  logic [2*W-1:0]     disp_cls, disp_rdy;
  logic [W*TAGW-1:0]  disp_src0, disp_src1, disp_dst;
  logic [NB-1:0]      bc_valid;
  logic [NB*TAGW-1:0] bc_tag;
  logic [W-1:0]       route_valid, addr_copy;
  logic [2*W-1:0]     route_dest;
  logic               disp_stall, iss_valid, iss_mode;
  logic [1:0]         iss_cls;
  logic [TAGW-1:0]    iss_dst;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mfu_dispatch_top uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_valid(disp_valid), .disp_cls(disp_cls), .disp_src0(disp_src0),
    .disp_src1(disp_src1), .disp_rdy(disp_rdy), .disp_dst(disp_dst),
    .bc_valid(bc_valid), .bc_tag(bc_tag),
    .route_valid(route_valid), .route_dest(route_dest), .addr_copy(addr_copy),
    .disp_stall(disp_stall), .iss_valid(iss_valid), .iss_mode(iss_mode),
    .iss_cls(iss_cls), .iss_dst(iss_dst)
  );

  // slot 0 always valid; codes: class 0 int,1 mem,2 fadd,3 fmds; route 0 int,1 addr,2 fp,3 mfu
  typedef struct packed {
    logic [1:0] c0; logic v1; logic [1:0] c1;
    logic [1:0] rv; logic [1:0] r0; logic [1:0] r1; logic [1:0] ac; logic st;
  } row_t;

  localparam row_t TBL [10] = '{
    '{2'd0, 1'b1, 2'd0, 2'b11, 2'd3, 2'd3, 2'b00, 1'b0},
    '{2'd1, 1'b1, 2'd3, 2'b11, 2'd3, 2'd2, 2'b01, 1'b0},
    '{2'd0, 1'b1, 2'd1, 2'b11, 2'd3, 2'd3, 2'b10, 1'b0},
    '{2'd0, 1'b1, 2'd0, 2'b11, 2'd0, 2'd0, 2'b00, 1'b0},
    '{2'd2, 1'b1, 2'd1, 2'b11, 2'd3, 2'd3, 2'b10, 1'b0},
    '{2'd1, 1'b1, 2'd0, 2'b11, 2'd1, 2'd0, 2'b00, 1'b0},
    '{2'd0, 1'b1, 2'd2, 2'b11, 2'd0, 2'd3, 2'b00, 1'b0},
    '{2'd0, 1'b1, 2'd3, 2'b11, 2'd0, 2'd2, 2'b00, 1'b0},
    '{2'd2, 1'b1, 2'd0, 2'b00, 2'd0, 2'd0, 2'b00, 1'b1},
    '{2'd3, 1'b0, 2'd0, 2'b01, 2'd2, 2'd0, 2'b00, 1'b0}
  };

  function automatic string row_req(int k);
    case (k)
      1:       return "R4";
      4, 9:    return "R1";
      6, 7:    return "R3";
      8:       return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    flush = 0; disp_valid = '0; disp_cls = '0; disp_rdy = '0;
    disp_src0 = '0; disp_src1 = '0; disp_dst = '0; bc_valid = '0; bc_tag = '0;
  endtask

  task automatic next_cycle();
    @(negedge clk);
    clear_in();
  endtask

  task automatic put(int s, logic [1:0] c, logic [5:0] t0, logic [5:0] t1, logic [1:0] r, logic [5:0] d);
    disp_valid[s] = 1'b1;
    disp_cls[2*s +: 2] = c;
    disp_src0[TAGW*s +: TAGW] = t0;
    disp_src1[TAGW*s +: TAGW] = t1;
    disp_rdy[2*s +: 2] = r;
    disp_dst[TAGW*s +: TAGW] = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    next_cycle(); #1;
    chk("R6 idle issue", iss_valid, 0);
    chk("R5 idle stall", disp_stall, 0);
    chk("R10 idle route", route_valid, 0);

    // steering table: entries never ready, so the station only fills
    for (int k = 0; k < 10; k++) begin
      next_cycle();
      put(0, TBL[k].c0, 6'd50, 6'd51, 2'b00, 6'(k));
      if (TBL[k].v1) put(1, TBL[k].c1, 6'd52, 6'd53, 2'b00, 6'(k + 16));
      #1;
      chk(row_req(k), route_valid, TBL[k].rv);
      chk(row_req(k), disp_stall, TBL[k].st);
      chk(row_req(k), addr_copy, TBL[k].ac);
      if (TBL[k].rv[0]) chk(row_req(k), route_dest[1:0], TBL[k].r0);
      if (TBL[k].rv[1]) chk(row_req(k), route_dest[3:2], TBL[k].r1);
      chk("R7 not ready", iss_valid, 0);
    end

    // R10: flush routes nothing, then station empty and mode fp
    next_cycle();
    flush = 1; put(0, 2'd2, 6'd1, 6'd2, 2'b11, 6'd3); put(1, 2'd2, 6'd1, 6'd2, 2'b11, 6'd4);
    #1; chk("R10 flush route", route_valid, 0);
    next_cycle();
    put(0, 2'd2, 6'd1, 6'd2, 2'b11, 6'd5);
    #1; chk("R10 empty after flush", disp_stall, 0);
    chk("R1 fadd route", route_dest[1:0], 3);
    next_cycle(); #1;
    chk("R10 fp mode issue", iss_valid, 1);
    chk("R10 issue dst", iss_dst, 5);
    chk("R10 issue mode", iss_mode, 0);
    chk("R1 issue cls", iss_cls, 2);

    // R9 / R7: wakeup by broadcast
    next_cycle();
    put(0, 2'd2, 6'd9, 6'd2, 2'b10, 6'd7);
    next_cycle(); #1;
    chk("R7 src0 pending", iss_valid, 0);
    bc_valid[0] = 1; bc_tag[5:0] = 6'd9;
    next_cycle(); #1;
    chk("R9 woken issue", iss_valid, 1);
    chk("R9 woken dst", iss_dst, 7);

    // R6: younger ready entry waits behind blocked head
    next_cycle();
    put(0, 2'd2, 6'd30, 6'd2, 2'b10, 6'd20);
    put(1, 2'd2, 6'd1, 6'd2, 2'b11, 6'd21);
    next_cycle(); #1; chk("R6 head blocks", iss_valid, 0);
    next_cycle(); #1; chk("R6 head blocks", iss_valid, 0);
    bc_valid[1] = 1; bc_tag[11:6] = 6'd30;
    next_cycle(); #1;
    chk("R6 oldest first", iss_valid, 1); chk("R6 oldest dst", iss_dst, 20);
    next_cycle(); #1;
    chk("R6 younger next", iss_valid, 1); chk("R6 younger dst", iss_dst, 21);

    // R8: int then fadd, each needs a mode switch
    next_cycle();
    put(0, 2'd0, 6'd1, 6'd2, 2'b11, 6'd10);
    put(1, 2'd2, 6'd1, 6'd2, 2'b11, 6'd11);
    #1; chk("R2 int to mfu", route_dest[1:0], 3);
    for (int j = 1; j <= 8; j++) begin
      next_cycle(); #1;
      chk("R8 penalty gap", iss_valid, (j == 4 || j == 8) ? 1 : 0);
      if (j == 4) begin chk("R8 int dst", iss_dst, 10); chk("R8 int mode", iss_mode, 1); end
      if (j == 8) begin chk("R8 fadd dst", iss_dst, 11); chk("R8 fadd mode", iss_mode, 0); end
    end

    // R11 / R2: credit saturates at 16, threshold includes equality
    next_cycle(); flush = 1;
    repeat (6) next_cycle();
    begin
      logic [1:0] exp_r [5];
      exp_r = '{2'd3, 2'd3, 2'd0, 2'd3, 2'd3};
      for (int b = 0; b < 5; b++) begin
        next_cycle();
        put(0, 2'd0, 6'd40, 6'd41, 2'b00, 6'(b));
        if (b < 4) put(1, 2'd0, 6'd40, 6'd41, 2'b00, 6'(b + 8));
        #1;
        chk("R11 credit slot0", route_dest[1:0], exp_r[b]);
        if (b < 4) chk("R2 credit slot1", route_dest[3:2], exp_r[b]);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule